// File: doc/BRIEF.md
# Byte-Lane Read Output Masking

This block sits at the end of the read data path of a synchronous DRAM device model. The upstream read logic has already applied the CAS latency. It presents one beat of read data per clock, together with a valid flag. The block registers each beat onto a 16-bit output bus split into two byte lanes. Each lane has its own output enable, so the pad ring can tri-state that lane.

Two mask pins, one per byte lane, control those enables. A mask pin sampled high turns its lane's driver off exactly two clock edges later, whatever CAS latency the read logic uses. The lane stays off for as long as the pin stays high, and it comes back on two edges after the pin falls. Masking only gates the drivers. The burst keeps advancing upstream, so a beat that falls inside a mask window is dropped and is not replayed later. When no read beat is valid, both lanes are off.

Top module: `rdq_lane_mask`

## Requirements
- R1: While reset is asserted, `dq_oe` is 2'b00 and `dq_out` is all zeros.
- R2: If `mask_hi` is high at rising edge n, `dq_oe[1]` (the enable for bits 15:8) is low after edge n+2.
- R3: `mask_lo` acts on `dq_oe[0]` (the enable for bits 7:0) with the same two-edge timing, and it has no effect on the upper lane. `mask_hi` likewise has no effect on the lower lane.
- R4: After edge n+2, a lane whose mask was low at edge n is enabled whenever `rd_valid` was high at edge n+2. A lane therefore resumes two edges after its mask falls.
- R5: If `rd_valid` is low at edge n, both bits of `dq_oe` are low after edge n, whatever the mask pins are doing.
- R6: If `rd_valid` is high at edge n, `dq_out` takes the value of `rd_data` at edge n. If `rd_valid` is low, `dq_out` holds its previous value.
- R7: Masking never stalls the data path. A beat presented while its lane is masked is lost, and the next unmasked beat shows its own data, not the dropped one.
- R8: The two-edge mask latency is the same for bursts that start two or three cycles after the read command, that is, CAS latency 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_data | input | 16 | Read beat from the internal read path |
| rd_valid | input | 1 | High when `rd_data` carries a valid read beat |
| mask_hi | input | 1 | Upper byte-lane mask pin (bits 15:8) |
| mask_lo | input | 1 | Lower byte-lane mask pin (bits 7:0) |
| dq_out | output | 16 | Registered output data |
| dq_oe | output | 2 | Lane output enables: bit 1 drives bits 15:8, bit 0 drives bits 7:0 |

## Verification
The hardest case to reach is a mask edge that lines up with a burst edge. Examples are a mask that rises two cycles before the first valid beat, or one that falls exactly as the burst ends. A normal read sequence rarely produces these alignments. The bench reaches them in two ways. It runs bursts at both CAS latencies with the mask windows placed at chosen offsets from the read command. It then sweeps every three-cycle pattern of the two mask pins and the valid flag, so each mask history lands on every valid and idle beat.

// File: rtl/rdq_mask_pkg.sv
package rdq_mask_pkg;

  // Two byte lanes, one mask pin each.
  localparam int unsigned NUM_LANES      = 2;
  localparam int unsigned LANE_UPPER     = 1;
  localparam int unsigned LANE_LOWER     = 0;

  // Clock edges between sampling a mask pin and the driver reacting.
  localparam int unsigned MASK_DELAY_DEF = 2;

  // Output driver state of one lane.
  typedef enum logic {
    LANE_HIZ   = 1'b0,
    LANE_DRIVE = 1'b1
  } lane_drv_e;

endpackage

// File: rtl/rdq_rst_sync.sv
module rdq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  // Shift ones in after release; the chain clears at once on assert.
  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rdq_mask_pipe.sv
module rdq_mask_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_in,
  output logic mask_out
);

  logic [DEPTH-1:0] stg_q;
  logic [DEPTH-1:0] stg_nxt;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb begin
        stg_nxt = mask_in;
      end
    end else begin : g_chain
      always_comb begin
        stg_nxt = {stg_q[DEPTH-2:0], mask_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign mask_out = stg_q[DEPTH-1];

  generate
    if (DEPTH == 2) begin : g_chk2
      AST_PIPE_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_in |-> ##2 mask_out) else $error("mask pipe lost a pulse"); // R2
    end
  endgenerate

endmodule

// File: rtl/rdq_lane_drv.sv
module rdq_lane_drv
  import rdq_mask_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [LANE_W-1:0] rd_lane,
  input  logic              mask_late,
  output logic [LANE_W-1:0] lane_q,
  output logic              lane_oe
);

  logic [LANE_W-1:0] data_q;
  logic [LANE_W-1:0] data_nxt;
  logic              data_en;
  lane_drv_e         drv_q;
  lane_drv_e         drv_nxt;

  // Capture a beat only when it is valid; the mask has no say here.
  always_comb begin
    data_en  = rd_valid;
    data_nxt = data_en ? rd_lane : data_q;
  end

  always_comb begin
    if (rd_valid && !mask_late) begin
      drv_nxt = LANE_DRIVE;
    end else begin
      drv_nxt = LANE_HIZ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      drv_q  <= LANE_HIZ;
    end else begin
      data_q <= data_nxt;
      drv_q  <= drv_nxt;
    end
  end

  assign lane_q  = data_q;
  assign lane_oe = (drv_q == LANE_DRIVE);

  AST_MASKED_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mask_late |=> !lane_oe) else $error("masked lane driven"); // R2
  AST_UNMASKED_LANE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_late && rd_valid) |=> lane_oe) else $error("lane did not resume"); // R4
  AST_IDLE_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !lane_oe) else $error("idle lane driven"); // R5
  AST_IDLE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(lane_q)) else $error("lane data moved while idle"); // R6

endmodule

// File: rtl/rdq_lane_mask.sv
module rdq_lane_mask
  import rdq_mask_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MASK_LAT = MASK_DELAY_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    rd_data,
  input  logic                 rd_valid,
  input  logic                 mask_hi,
  input  logic                 mask_lo,
  output logic [DATA_W-1:0]    dq_out,
  output logic [NUM_LANES-1:0] dq_oe
);

  localparam int unsigned LANE_W = DATA_W / NUM_LANES;

  logic                 rst_n_q;
  logic [NUM_LANES-1:0] mask_pins;
  logic [NUM_LANES-1:0] mask_late;

  rdq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_q)
  );

  always_comb begin
    mask_pins             = '0;
    mask_pins[LANE_UPPER] = mask_hi;
    mask_pins[LANE_LOWER] = mask_lo;
  end

  // One mask delay line and one driver for each byte lane.
  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      rdq_mask_pipe #(.DEPTH(MASK_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n_q),
        .mask_in  (mask_pins[g]),
        .mask_out (mask_late[g])
      );

      rdq_lane_drv #(.LANE_W(LANE_W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n_q),
        .rd_valid  (rd_valid),
        .rd_lane   (rd_data[g*LANE_W +: LANE_W]),
        .mask_late (mask_late[g]),
        .lane_q    (dq_out[g*LANE_W +: LANE_W]),
        .lane_oe   (dq_oe[g])
      );
    end
  endgenerate

  AST_BEAT_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n_q)
    rd_valid |=> (dq_out == $past(rd_data))) else $error("beat not presented"); // R7
  AST_NO_ENABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    !rd_valid |=> (dq_oe == '0)) else $error("enable without valid beat"); // R5

endmodule

// File: tb/rdq_lane_mask_bench.sv
`timescale 1ns/1ps
module rdq_lane_mask_bench;

  logic        clk;
  logic        rst_n;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        mask_hi;
  logic        mask_lo;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done   = 0;

  // Reference history built from the requirements.
  logic        h_hi1, h_hi2, h_lo1, h_lo2;
  logic [1:0]  exp_oe;
  logic        exp_vld;
  logic [15:0] exp_data;

  rdq_lane_mask u_rdq_lane_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mask_hi  (mask_hi),
    .mask_lo  (mask_lo),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_hi1 <= 1'b0; h_hi2 <= 1'b0; h_lo1 <= 1'b0; h_lo2 <= 1'b0;
      exp_oe <= 2'b00; exp_vld <= 1'b0; exp_data <= 16'h0000;
    end else begin
      h_hi1 <= mask_hi; h_hi2 <= h_hi1;
      h_lo1 <= mask_lo; h_lo2 <= h_lo1;
      exp_oe  <= {rd_valid & ~h_hi2, rd_valid & ~h_lo2};
      exp_vld <= rd_valid;
      if (rd_valid) exp_data <= rd_data;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(dq_oe[1] == exp_oe[1], "R2", dq_oe[1], exp_oe[1]);
      check(dq_oe[0] == exp_oe[0], "R3", dq_oe[0], exp_oe[0]);
      check(dq_out == exp_data, "R6", dq_out, exp_data);
      if (!exp_vld) check(dq_oe == 2'b00, "R5", dq_oe, 0);
    end
  end

  // Read command at cycle 0; beats start cl cycles later.
  task automatic run_burst(input int cl, input int base, input int len,
                           input int hon, input int hoff, input int lon, input int loff);
    logic        v;
    logic        hm2, lm2;
    logic [15:0] beat;
    for (int i = 0; i < cl + len + 3; i++) begin
      v    = (i >= cl) && (i < cl + len);
      beat = 16'((base + i - cl) * 257);
      rd_valid = v;
      rd_data  = v ? beat : 16'hA55A;
      mask_hi  = (i >= hon) && (i < hoff);
      mask_lo  = (i >= lon) && (i < loff);
      @(posedge clk);
      @(negedge clk);
      hm2 = (i - 2 >= hon) && (i - 2 < hoff);
      lm2 = (i - 2 >= lon) && (i - 2 < loff);
      check(dq_oe[1] == (v && !hm2), "R8", dq_oe[1], v && !hm2);
      check(dq_oe[0] == (v && !lm2), "R8", dq_oe[0], v && !lm2);
      if (v) check(dq_out == beat, "R7", dq_out, beat);
      if (v && i == hoff + 2) check(dq_oe[1] == 1'b1, "R4", dq_oe[1], 1);
      if (v && i == loff + 2) check(dq_oe[0] == 1'b1, "R4", dq_oe[0], 1);
    end
    rd_valid = 1'b0; mask_hi = 1'b0; mask_lo = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rd_valid = 1'b0; rd_data = 16'h0000; mask_hi = 1'b0; mask_lo = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held, even with stimulus applied
    rd_valid = 1'b1; rd_data = 16'hFFFF;
    @(negedge clk);
    check(dq_oe == 2'b00, "R1", dq_oe, 0);
    check(dq_out == 16'h0000, "R1", dq_out, 0);
    rd_valid = 1'b0; rd_data = 16'h0000;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_en = 1'b1;

    // CAS latency 2 and 3, upper and lower windows placed around burst edges
    run_burst(2, 16, 8, 3, 6, 9, 11);
    run_burst(3, 40, 8, 4, 7, 1, 4);
    run_burst(2, 80, 6, 0, 3, 5, 9);
    run_burst(3, 120, 6, 6, 11, 2, 3);
    run_burst(2, 160, 10, 2, 12, 2, 12);

    // Every three-cycle pattern of {mask_hi, mask_lo, rd_valid}
    for (int seq = 0; seq < 512; seq++) begin
      for (int k = 0; k < 3; k++) begin
        logic [2:0] sym;
        sym = 3'((seq >> (3 * k)) & 7);
        mask_hi  = sym[2];
        mask_lo  = sym[1];
        rd_valid = sym[0];
        rd_data  = 16'((seq * 3 + k) * 40503);
        @(negedge clk);
      end
    end
    rd_valid = 1'b0; mask_hi = 1'b0; mask_lo = 1'b0;
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule